// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a 32-bit load/store processor whose datapath reuses a single ALU and a single memory port across several clock cycles per instruction. It watches the 6-bit opcode held in the instruction register and the ALU zero flag. In every cycle it drives the datapath's write enables, its multiplexer selects and the ALU operation class. Register operands and a branch target are fetched and computed during decode, before the instruction type is known. Each instruction then finishes in three, four or five cycles depending on its kind.

Four instruction kinds are sequenced: register-to-register arithmetic, word load, word store and branch-if-equal. The datapath, register file and memory sit outside the block. The block assumes the datapath loads its A, B and ALU-result holding registers on every clock. An asynchronously asserted, active-low reset is released into the state machine through a short synchronizer. Until that release completes, every write enable stays low and the machine waits in fetch.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it goes high, every output is 0. The first active cycle is then a fetch.
- R2: Fetch cycle drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_src`=0 (address from PC), `alu_src_a`=0 (PC), `alu_src_b`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=0 (PC takes the live ALU result). All other outputs are 0. A decode cycle always follows.
- R3: Decode cycle drives `alu_src_a`=0, `alu_src_b`=11 (sign-extended immediate shifted left by 2), `alu_op`=00, and all else 0. This happens for every opcode.
- R4: For load (opcode 100011) and store (opcode 101011), the third cycle drives `alu_src_a`=1 (A), `alu_src_b`=10 (sign-extended immediate) and `alu_op`=00.
- R5: For arithmetic (opcode 000000), the third cycle drives `alu_src_a`=1, `alu_src_b`=00 (B) and `alu_op`=10 (the ALU decodes the function field).
- R6: For branch (opcode 000100), the third cycle drives `alu_src_a`=1, `alu_src_b`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=1 (PC takes the held ALU result). Fetch follows, so a branch takes 3 cycles.
- R7: For a load, the fourth cycle drives `mem_rd`=1, `addr_src`=1 and `mdr_ld`=1. The fifth cycle drives `reg_wr`=1, `mem_to_reg`=1 and `reg_dst`=0 (destination in IR bits 20:16). A load takes 5 cycles.
- R8: For a store, the fourth cycle drives `mem_wr`=1 and `addr_src`=1, then returns to fetch. A store takes 4 cycles.
- R9: For arithmetic, the fourth cycle drives `reg_wr`=1, `reg_dst`=1 (destination in IR bits 15:11) and `mem_to_reg`=0, then returns to fetch. Arithmetic takes 4 cycles.
- R10: Any other opcode raises `illegal` during its decode cycle. Fetch follows directly, with no write enable asserted in between.
- R11: `pc_load` is 1 exactly when `pc_wr` is 1, or when `pc_wr_cond` and `zero` are both 1.
- R12: `mem_rd` and `mem_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write of B |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if zero |
| pc_load | output | 1 | Resolved PC load enable |
| reg_wr | output | 1 | Register file write |
| mdr_ld | output | 1 | Memory data register load |
| addr_src | output | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_to_reg | output | 1 | Write data: 0 ALU result register, 1 MDR |
| reg_dst | output | 1 | Destination: 0 IR[20:16], 1 IR[15:11] |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 A register |
| alu_src_b | output | 2 | ALU B: 00 B, 01 four, 10 imm, 11 imm<<2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| pc_src | output | 1 | PC source: 0 ALU output, 1 ALU result register |
| illegal | output | 1 | Unknown opcode seen in decode |

## Verification
The assertions check on every cycle that memory is never read and written together, and that a PC load is always backed by a PC write request. They also check the follow-on steps: fetch leads to decode, and branch, store, register write-back and illegal decode each lead back to fetch. Only the bench's program run can show two things. First, that each instruction kind gets the exact select and enable pattern, cycle by cycle. Second, that these patterns, applied to a real datapath, give the right register and memory contents, including a taken branch that skips an instruction and a branch that is not taken.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_ARITH = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_EXEC,
    ST_BRANCH,
    ST_LDMEM,
    ST_STMEM,
    ST_RDONE,
    ST_LDWB
  } step_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       reg_wr;
    logic       mdr_ld;
    logic       addr_src;
    logic       mem_to_reg;
    logic       reg_dst;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic       pc_src;
  } ctrl_t;
endpackage

// File: rtl/mcs_rst_sync.sv
module mcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/mcs_next_step.sv
module mcs_next_step
  import mcs_pkg::*;
(
  input  step_e            cur,
  input  logic [OPC_W-1:0] opcode,
  output step_e            nxt,
  output logic             bad_opc
);
  always_comb begin
    nxt     = ST_FETCH;
    bad_opc = 1'b0;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_ARITH)                             nxt = ST_EXEC;
        else if (opcode == OPC_LOAD || opcode == OPC_STORE)  nxt = ST_ADDR;
        else if (opcode == OPC_BEQ)                          nxt = ST_BRANCH;
        else begin
          nxt     = ST_FETCH;
          bad_opc = 1'b1;
        end
      end
      ST_ADDR:   nxt = (opcode == OPC_LOAD) ? ST_LDMEM : ST_STMEM;
      ST_EXEC:   nxt = ST_RDONE;
      ST_LDMEM:  nxt = ST_LDWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcs_ctrl_decode.sv
module mcs_ctrl_decode
  import mcs_pkg::*;
(
  input  step_e cur,
  input  logic  active,
  output ctrl_t ctl
);
  ctrl_t raw;

  always_comb begin
    raw = '0;
    unique case (cur)
      ST_FETCH: begin
        raw.mem_rd    = 1'b1;
        raw.ir_wr     = 1'b1;
        raw.pc_wr     = 1'b1;
        raw.alu_src_b = 2'b01;
      end
      ST_DECODE: raw.alu_src_b = 2'b11;
      ST_ADDR: begin
        raw.alu_src_a = 1'b1;
        raw.alu_src_b = 2'b10;
      end
      ST_EXEC: begin
        raw.alu_src_a = 1'b1;
        raw.alu_op    = 2'b10;
      end
      ST_BRANCH: begin
        raw.alu_src_a  = 1'b1;
        raw.alu_op     = 2'b01;
        raw.pc_wr_cond = 1'b1;
        raw.pc_src     = 1'b1;
      end
      ST_LDMEM: begin
        raw.mem_rd   = 1'b1;
        raw.addr_src = 1'b1;
        raw.mdr_ld   = 1'b1;
      end
      ST_STMEM: begin
        raw.mem_wr   = 1'b1;
        raw.addr_src = 1'b1;
      end
      ST_RDONE: begin
        raw.reg_wr  = 1'b1;
        raw.reg_dst = 1'b1;
      end
      ST_LDWB: begin
        raw.reg_wr     = 1'b1;
        raw.mem_to_reg = 1'b1;
      end
      default: raw = '0;
    endcase
    ctl = active ? raw : '0;
  end
endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             pc_load,
  output logic             reg_wr,
  output logic             mdr_ld,
  output logic             addr_src,
  output logic             mem_to_reg,
  output logic             reg_dst,
  output logic             alu_src_a,
  output logic [1:0]       alu_src_b,
  output logic [1:0]       alu_op,
  output logic             pc_src,
  output logic             illegal
);
  logic  rst_ok;
  step_e step_q, step_d;
  logic  bad_opc;
  ctrl_t ctl;

  mcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  mcs_next_step u_next (
    .cur     (step_q),
    .opcode  (opcode),
    .nxt     (step_d),
    .bad_opc (bad_opc)
  );

  // state register; enabled only once reset release has been synchronised
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= ST_FETCH;
    else if (rst_ok) step_q <= step_d;
  end

  mcs_ctrl_decode u_dec (
    .cur    (step_q),
    .active (rst_ok),
    .ctl    (ctl)
  );

  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign pc_load    = ctl.pc_wr | (ctl.pc_wr_cond & zero);
  assign reg_wr     = ctl.reg_wr;
  assign mdr_ld     = ctl.mdr_ld;
  assign addr_src   = ctl.addr_src;
  assign mem_to_reg = ctl.mem_to_reg;
  assign reg_dst    = ctl.reg_dst;
  assign alu_src_a  = ctl.alu_src_a;
  assign alu_src_b  = ctl.alu_src_b;
  assign alu_op     = ctl.alu_op;
  assign pc_src     = ctl.pc_src;
  assign illegal    = bad_opc & rst_ok;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       zero,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       pc_load,
  input logic       reg_wr,
  input logic       mdr_ld,
  input logic       mem_to_reg,
  input logic [1:0] alu_src_b,
  input logic       illegal
);
  p_mem_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_wr |=> (alu_src_b == 2'b11) && !ir_wr);

  p_branch_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_cond |=> ir_wr);

  p_load_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdr_ld |=> (reg_wr && mem_to_reg));

  p_store_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_wr);

  p_wb_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ir_wr);

  p_illegal_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ir_wr);

  p_pcload_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (pc_wr || (pc_wr_cond && zero)));
endmodule

bind mc_ctrl_seq mcs_checker u_mcs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .zero       (zero),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .ir_wr      (ir_wr),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .pc_load    (pc_load),
  .reg_wr     (reg_wr),
  .mdr_ld     (mdr_ld),
  .mem_to_reg (mem_to_reg),
  .alu_src_b  (alu_src_b),
  .illegal    (illegal)
);

// File: tb/test_mc_ctrl_seq.sv
`timescale 1ns/1ps
module test_mc_ctrl_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] opcode;
  logic zero;
  logic mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_load, reg_wr, mdr_ld;
  logic addr_src, mem_to_reg, reg_dst, alu_src_a, pc_src, illegal;
  logic [1:0] alu_src_b, alu_op;

  mc_ctrl_seq i_mc_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .pc_load(pc_load), .reg_wr(reg_wr),
    .mdr_ld(mdr_ld), .addr_src(addr_src), .mem_to_reg(mem_to_reg),
    .reg_dst(reg_dst), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .alu_op(alu_op), .pc_src(pc_src), .illegal(illegal)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_illegal = 0;

  // ---------------- behavioural datapath ----------------
  logic [31:0] mem [0:31];
  logic [31:0] rf  [0:31];
  logic [31:0] pc, ir, mdr, ra, rb, aluout;
  logic [31:0] opa, opb, alu_res, maddr;

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  always_comb begin
    logic [31:0] sx;
    sx = {{16{ir[15]}}, ir[15:0]};
    opa = alu_src_a ? ra : pc;
    case (alu_src_b)
      2'b00:   opb = rb;
      2'b01:   opb = 32'd4;
      2'b10:   opb = sx;
      default: opb = {sx[29:0], 2'b00};
    endcase
    case (alu_op)
      2'b00: alu_res = opa + opb;
      2'b01: alu_res = opa - opb;
      default: case (ir[5:0])
        6'h22:   alu_res = opa - opb;
        6'h24:   alu_res = opa & opb;
        6'h25:   alu_res = opa | opb;
        default: alu_res = opa + opb;
      endcase
    endcase
    maddr = addr_src ? aluout : pc;
  end
  assign zero   = (alu_res == 32'd0);
  assign opcode = ir[31:26];

  always @(posedge clk) begin
    ra     <= rf[ir[25:21]];
    rb     <= rf[ir[20:16]];
    aluout <= alu_res;
    if (ir_wr)   ir  <= mem[maddr[6:2]];
    if (mdr_ld)  mdr <= mem[maddr[6:2]];
    if (mem_wr)  mem[maddr[6:2]] <= rb;
    if (pc_load) pc  <= pc_src ? aluout : alu_res;
    if (reg_wr) begin
      if ((reg_dst ? ir[15:11] : ir[20:16]) != 5'd0)
        rf[reg_dst ? ir[15:11] : ir[20:16]] <= mem_to_reg ? mdr : aluout;
    end
    if (illegal) n_illegal <= n_illegal + 1;
  end

  // ---------------- cycle reference model ----------------
  int m_rs   = 0;   // edges seen since reset release
  int m_step = 1;   // 1..5 within an instruction
  logic [5:0] m_op = 6'd0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs   <= 0;
      m_step <= 1;
    end else begin
      if (m_rs < 2) m_rs <= m_rs + 1;
      if (m_rs >= 2) begin
        case (m_step)
          1: m_step <= 2;
          2: begin
            m_op <= opcode;
            if (opcode == 6'b000000 || opcode == 6'b100011 ||
                opcode == 6'b101011 || opcode == 6'b000100) m_step <= 3;
            else m_step <= 1;
          end
          3: m_step <= (m_op == 6'b000100) ? 1 : 4;
          4: m_step <= (m_op == 6'b100011) ? 5 : 1;
          default: m_step <= 1;
        endcase
      end
    end
  end

  // order: mem_rd mem_wr ir_wr pc_wr pc_wr_cond pc_load reg_wr mdr_ld
  //        addr_src mem_to_reg reg_dst alu_src_a alu_src_b[2] alu_op[2] pc_src illegal
  function automatic logic [17:0] expect_vec(input int rs, input int step,
      input logic [5:0] op_in, input logic [5:0] op_held, input logic z, output string tag);
    logic [17:0] v;
    logic known;
    v = '0;
    tag = "R1";
    if (rs < 2) return v;
    known = (op_in == 6'b000000 || op_in == 6'b100011 || op_in == 6'b101011 || op_in == 6'b000100);
    case (step)
      1: begin tag = "R2"; v = {8'b10110100, 4'b0000, 2'b01, 2'b00, 1'b0, 1'b0}; end
      2: begin tag = known ? "R3" : "R10"; v = {8'b0, 4'b0000, 2'b11, 2'b00, 1'b0, !known}; end
      3: begin
        if (op_held == 6'b000100) begin
          tag = "R6"; v = {4'b0000, 1'b1, z, 2'b00, 4'b0001, 2'b00, 2'b01, 1'b1, 1'b0};
        end else if (op_held == 6'b000000) begin
          tag = "R5"; v = {8'b0, 4'b0001, 2'b00, 2'b10, 1'b0, 1'b0};
        end else begin
          tag = "R4"; v = {8'b0, 4'b0001, 2'b10, 2'b00, 1'b0, 1'b0};
        end
      end
      4: begin
        if (op_held == 6'b100011) begin
          tag = "R7"; v = {8'b10000001, 4'b1000, 6'b0};
        end else if (op_held == 6'b101011) begin
          tag = "R8"; v = {8'b01000000, 4'b1000, 6'b0};
        end else begin
          tag = "R9"; v = {8'b00000010, 4'b0010, 6'b0};
        end
      end
      default: begin tag = "R7"; v = {8'b00000010, 4'b0100, 6'b0}; end
    endcase
    return v;
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [17:0] dut_vec;
  assign dut_vec = {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_load, reg_wr, mdr_ld,
                    addr_src, mem_to_reg, reg_dst, alu_src_a, alu_src_b, alu_op, pc_src, illegal};

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    string tag;
    logic [17:0] ev;
    ev = expect_vec(m_rs, m_step, opcode, m_op, zero, tag);
    n_cmp++;
    if (dut_vec !== ev) begin
      n_bad++;
      $display("FAIL %s cycle step=%0d actual=%b expected=%b", tag, m_step, dut_vec, ev);
    end
  end

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < 32; i++) begin mem[i] = 32'd0; rf[i] = 32'd0; end
    mem[0]  = enc_i(6'b100011, 0, 1, 16'd64);      // lw  r1
    mem[1]  = enc_i(6'b100011, 0, 2, 16'd68);      // lw  r2
    mem[2]  = enc_r(1, 2, 3, 6'h20);               // add r3
    mem[3]  = enc_i(6'b000100, 1, 2, 16'd1);       // beq taken
    mem[4]  = enc_r(1, 1, 4, 6'h20);               // skipped
    mem[5]  = enc_i(6'b101011, 0, 3, 16'd72);      // sw  r3
    mem[6]  = {6'b111111, 26'd0};                  // unknown opcode
    mem[7]  = enc_i(6'b000100, 1, 3, 16'd1);       // beq not taken
    mem[8]  = enc_r(3, 1, 5, 6'h22);               // sub r5
    mem[9]  = enc_i(6'b100011, 0, 6, 16'd72);      // lw  r6
    mem[10] = enc_i(6'b000100, 0, 0, 16'hFFFF);    // spin
    mem[16] = 32'd5;
    mem[17] = 32'd5;
    pc = 32'd0; ir = 32'd0; mdr = 32'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_eq("R1 outputs in reset", {14'd0, dut_vec}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 outputs during sync", {14'd0, dut_vec}, 32'd0);
    repeat (80) @(negedge clk);
    check_eq("R7 lw r1", rf[1], 32'd5);
    check_eq("R7 lw r2", rf[2], 32'd5);
    check_eq("R9 add r3", rf[3], 32'd10);
    check_eq("R6 taken branch skips r4", rf[4], 32'd0);
    check_eq("R5 sub r5", rf[5], 32'd5);
    check_eq("R8 sw to word 18", mem[18], 32'd10);
    check_eq("R7 lw r6 from stored word", rf[6], 32'd10);
    check_eq("R10 one illegal pulse", n_illegal, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R1 outputs after second reset", {14'd0, dut_vec}, 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule